// File: doc/BRIEF.md
# Coulomb Tally Register

This block keeps a 16-bit running charge total for a battery monitor. An external ramp integrator sends one pulse per charge quantum: a pulse on the up line means the battery is charging, a pulse on the down line means it is discharging. The block adds or subtracts one for each pulse. The total stops at both ends of its range and does not wrap. The live total goes straight out to a threshold monitor.

At power-up the state of the battery is unknown, so the total starts at midscale. Firmware can then correct it in two ways. It can write the high or low byte directly, but the block applies such a write only while the shutdown control is set. It can also select the charge-done mode for the shared pin. In that mode the pin is synchronised, and while it is held low the total is forced to full scale.

Reads are done one byte at a time. Reading the high byte returns the live high byte and takes a snapshot of the low byte. A later low-byte read returns that snapshot, so a two-byte read never mixes halves from different counts. Host writes and reads are single-cycle strobes with no handshake and no back-pressure. Every strobe is taken in the cycle it is presented, and the integrator pulses are treated the same way.

Top module: `coulomb_tally`

## Requirements
- R1: While rst_n is low the total is 7FFFh, the pin synchroniser holds the inactive (high) level, and the low-byte snapshot holds FFh.
- R2: With shutdown at 0, an inc_pulse without dec_pulse raises the total by one at the next clock edge. A dec_pulse without inc_pulse lowers it by one. Both pulses together leave it unchanged.
- R3: When pin_mode is 2'b01 (charge-done mode) and the chg_done_n level, after two synchroniser flops, is low, the total becomes FFFFh at the next edge. Other pin_mode values (00 off, 10 alert, 11 reserved) give the pin no effect on the total.
- R4: A write strobe (wr_en) with wr_sel=1 replaces bits 15:8 with wr_data, and with wr_sel=0 it replaces bits 7:0. The write takes effect only while shutdown is 1. Otherwise the total is left as the other rules make it.
- R5: While shutdown is 1, integrator pulses do not change the total.
- R6: rd_data is combinational. With rd_sel=1 it shows bits 15:8 of the live total, and a read strobe (rd_en) with rd_sel=1 copies bits 7:0 into the snapshot at that edge. With rd_sel=0, rd_data shows the snapshot.
- R7: An up pulse at FFFFh leaves FFFFh, and a down pulse at 0000h leaves 0000h.
- R8: When several sources act in the same cycle, an accepted host write wins over a charge-done preset, and the preset wins over an integrator pulse.
- R9: count_out always shows the registered total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc_pulse | input | 1 | One charge quantum in the charging direction |
| dec_pulse | input | 1 | One charge quantum in the discharging direction |
| shutdown | input | 1 | Shutdown control; enables host writes and stops counting |
| pin_mode | input | 2 | Shared-pin mode; 2'b01 selects charge-done |
| chg_done_n | input | 1 | Asynchronous active-low charge-done pin level |
| wr_en | input | 1 | Host byte write strobe |
| wr_sel | input | 1 | Write byte select: 1 high byte, 0 low byte |
| wr_data | input | 8 | Host write byte |
| rd_en | input | 1 | Host byte read strobe |
| rd_sel | input | 1 | Read byte select: 1 high byte, 0 snapshot low byte |
| rd_data | output | 8 | Read byte |
| count_out | output | 16 | Live total for the threshold monitor |

## Verification
The total register is visible on count_out, so a wrong step, a missed saturation or a write slipping through shows up one edge after the stimulus that caused it. A fault in the synchroniser shows as a preset that comes one cycle early or late, or not at all, relative to the pin edge. A stale or wrongly loaded snapshot appears only on the first low-byte read after a high-byte read, so the bench places reads right next to count changes to expose it at once.

// File: rtl/ccnt_pkg.sv
package ccnt_pkg;

  typedef enum logic [1:0] {
    PIN_OFF      = 2'b00,
    PIN_CHG_DONE = 2'b01,
    PIN_ALERT    = 2'b10,
    PIN_RSVD     = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    SRC_STEP   = 2'b00,
    SRC_PRESET = 2'b01,
    SRC_HOST   = 2'b10
  } next_src_e;

endpackage

// File: rtl/ccnt_sync.sv
module ccnt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= 1'b1;
        else        q_r <= d;
      end
      assign q = q_r;
    end else begin : g_chain
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
      end
      assign q = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ccnt_step.sv
module ccnt_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] cur,
  input  logic         up,
  input  logic         down,
  input  logic         run,
  output logic [W-1:0] nxt
);

  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] TOP  = '1;
  localparam logic [W-1:0] BASE = '0;

  logic go_up;
  logic go_down;

  assign go_up   = run && up && !down && (cur != TOP);
  assign go_down = run && down && !up && (cur != BASE);

  always_comb begin
    nxt = cur;
    if (go_up)        nxt = cur + ONE;
    else if (go_down) nxt = cur - ONE;
  end

endmodule

// File: rtl/ccnt_shadow.sv
module ccnt_shadow #(
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  logic                  rd_sel,
  input  logic [2*BYTE_W-1:0]   live,
  output logic [BYTE_W-1:0]     rd_data
);

  logic [BYTE_W-1:0] lo_snap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 lo_snap <= '1;
    else if (rd_en && rd_sel)   lo_snap <= live[BYTE_W-1:0];
  end

  assign rd_data = rd_sel ? live[2*BYTE_W-1:BYTE_W] : lo_snap;

endmodule

// File: rtl/coulomb_tally.sv
module coulomb_tally
  import ccnt_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inc_pulse,
  input  logic                dec_pulse,
  input  logic                shutdown,
  input  logic [1:0]          pin_mode,
  input  logic                chg_done_n,
  input  logic                wr_en,
  input  logic                wr_sel,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic                rd_sel,
  output logic [BYTE_W-1:0]   rd_data,
  output logic [2*BYTE_W-1:0] count_out
);

  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] MID  = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] FULL = '1;

  logic             pin_q;
  logic             preset_req;
  logic             host_wr;
  next_src_e        src;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic [CNT_W-1:0] step_val;
  logic [CNT_W-1:0] host_val;

  ccnt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (chg_done_n),
    .q     (pin_q)
  );

  assign preset_req = (pin_mode == PIN_CHG_DONE) && !pin_q;
  assign host_wr    = wr_en && shutdown;

  ccnt_step #(.W(CNT_W)) u_step (
    .cur  (count_q),
    .up   (inc_pulse),
    .down (dec_pulse),
    .run  (!shutdown),
    .nxt  (step_val)
  );

  always_comb begin
    if (wr_sel) host_val = {wr_data, count_q[BYTE_W-1:0]};
    else        host_val = {count_q[CNT_W-1:BYTE_W], wr_data};
  end

  always_comb begin
    if (host_wr)         src = SRC_HOST;
    else if (preset_req) src = SRC_PRESET;
    else                 src = SRC_STEP;
  end

  always_comb begin
    case (src)
      SRC_HOST:   count_d = host_val;
      SRC_PRESET: count_d = FULL;
      default:    count_d = step_val;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= MID;
    else        count_q <= count_d;
  end

  ccnt_shadow #(.BYTE_W(BYTE_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_sel  (rd_sel),
    .live    (count_q),
    .rd_data (rd_data)
  );

  assign count_out = count_q;

endmodule

// File: rtl/ccnt_checker.sv
module ccnt_checker #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                inc_pulse,
  input logic                dec_pulse,
  input logic                shutdown,
  input logic                wr_en,
  input logic                wr_sel,
  input logic [BYTE_W-1:0]   wr_data,
  input logic                rd_en,
  input logic                rd_sel,
  input logic [BYTE_W-1:0]   rd_data,
  input logic [2*BYTE_W-1:0] count_out,
  input logic                preset_req,
  input logic                host_wr
);

  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [CNT_W-1:0] MID  = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] FULL = '1;
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  AST_RESET_MID: assert property (@(posedge clk) !rst_n |=> count_out == MID); // R1

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown && inc_pulse && !dec_pulse && !preset_req && count_out != FULL)
    |=> count_out == $past(count_out) + ONE); // R2

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown && dec_pulse && !inc_pulse && !preset_req && count_out != ZERO)
    |=> count_out == $past(count_out) - ONE); // R2

  AST_PRESET_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_req && !host_wr) |=> count_out == FULL); // R3

  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!shutdown && !preset_req)
    |=> (count_out == $past(count_out) || count_out == $past(count_out) + ONE ||
         count_out == $past(count_out) - ONE)); // R4

  AST_SHUTDOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && !wr_en && !preset_req) |=> $stable(count_out)); // R5

  AST_SNAPSHOT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel) |=> (rd_sel || rd_data == $past(count_out[BYTE_W-1:0]))); // R6

  AST_NO_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_out == FULL && !host_wr) |=> count_out != ZERO); // R7

  AST_NO_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (count_out == ZERO && !host_wr && !preset_req) |=> count_out != FULL); // R7

  AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && wr_sel) |=> count_out[CNT_W-1:BYTE_W] == $past(wr_data)); // R8

endmodule

bind coulomb_tally ccnt_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .inc_pulse  (inc_pulse),
  .dec_pulse  (dec_pulse),
  .shutdown   (shutdown),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .wr_data    (wr_data),
  .rd_en      (rd_en),
  .rd_sel     (rd_sel),
  .rd_data    (rd_data),
  .count_out  (count_out),
  .preset_req (preset_req),
  .host_wr    (host_wr)
);

// File: tb/coulomb_tally_test.sv
module coulomb_tally_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inc_pulse = 1'b0, dec_pulse = 1'b0, shutdown = 1'b0;
  logic [1:0]  pin_mode = 2'b00;
  logic        chg_done_n = 1'b1;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data;
  logic [15:0] count_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [15:0] m_count = 16'h7FFF;
  logic [7:0]  m_lo    = 8'hFF;
  logic [1:0]  m_sync  = 2'b11;

  always #2 clk = ~clk;

  coulomb_tally uut (
    .clk(clk), .rst_n(rst_n), .inc_pulse(inc_pulse), .dec_pulse(dec_pulse),
    .shutdown(shutdown), .pin_mode(pin_mode), .chg_done_n(chg_done_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .count_out(count_out)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: act=%0d cycles exp=<100000", cycles);
      summary();
      $finish;
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set(input logic i, input logic d, input logic sd, input logic [1:0] md,
                     input logic pin, input logic we, input logic ws, input logic [7:0] wd,
                     input logic re, input logic rs);
    inc_pulse = i; dec_pulse = d; shutdown = sd; pin_mode = md; chg_done_n = pin;
    wr_en = we; wr_sel = ws; wr_data = wd; rd_en = re; rd_sel = rs;
  endtask

  function automatic logic [15:0] model_next(output string tag);
    logic pre;
    logic [15:0] n;
    pre = (pin_mode == 2'b01) && !m_sync[1];
    n = m_count;
    tag = "R2";
    if (wr_en && shutdown) begin
      n = wr_sel ? {wr_data, m_count[7:0]} : {m_count[15:8], wr_data};
      tag = pre ? "R8" : "R4";
    end else if (pre) begin
      n = 16'hFFFF;
      tag = (inc_pulse || dec_pulse) ? "R8" : "R3";
    end else if (shutdown) begin
      tag = "R5";
    end else if (inc_pulse && !dec_pulse) begin
      if (m_count != 16'hFFFF) n = m_count + 16'd1; else tag = "R7";
    end else if (dec_pulse && !inc_pulse) begin
      if (m_count != 16'h0000) n = m_count - 16'd1; else tag = "R7";
    end else if (wr_en) begin
      tag = "R4";
    end
    return n;
  endfunction

  task automatic step(input string force_tag);
    string tag;
    logic [15:0] n;
    #1;
    chk({8'h00, rd_data}, {8'h00, rd_sel ? m_count[15:8] : m_lo}, "R6");
    @(posedge clk);
    n = model_next(tag);
    if (rd_en && rd_sel) m_lo = m_count[7:0];
    m_sync = {m_sync[0], chg_done_n};
    m_count = n;
    @(negedge clk);
    chk(count_out, m_count, (force_tag != "") ? force_tag : tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(count_out, 16'h7FFF, "R1");
    chk({8'h00, rd_data}, 16'h00FF, "R1");
    rst_n = 1'b1;

    // R2: counting, cancel on both pulses; R9 live output
    set(1,0,0,2'b00,1,0,0,8'h00,0,0); step("R9");
    step("R2"); step("R2");
    set(0,1,0,2'b00,1,0,0,8'h00,0,0); step("R2");
    set(1,1,0,2'b00,1,0,0,8'h00,0,0); step("R2");
    // R5: pulses ignored in shutdown
    set(1,0,1,2'b00,1,0,0,8'h00,0,0); step("R5");
    set(0,1,1,2'b00,1,0,0,8'h00,0,0); step("R5");
    // R4: write without shutdown ignored, then accepted
    set(0,0,0,2'b00,1,1,1,8'hAA,0,0); step("R4");
    set(0,0,1,2'b00,1,1,1,8'hFF,0,0); step("R4");
    set(0,0,1,2'b00,1,1,0,8'hFE,0,0); step("R4");
    chk(count_out, 16'hFFFE, "R4");
    // R7: top saturation
    set(1,0,0,2'b00,1,0,0,8'h00,0,0); step("R7"); step("R7"); step("R7");
    chk(count_out, 16'hFFFF, "R7");
    // R7: bottom saturation
    set(0,0,1,2'b00,1,1,1,8'h00,0,0); step("R4");
    set(0,0,1,2'b00,1,1,0,8'h01,0,0); step("R4");
    set(0,1,0,2'b00,1,0,0,8'h00,0,0); step("R7"); step("R7"); step("R7");
    chk(count_out, 16'h0000, "R7");
    // R3: pin in alert mode has no effect; charge-done mode presets after sync
    set(0,0,0,2'b10,0,0,0,8'h00,0,0); step("R3"); step("R3"); step("R3");
    chk(count_out, 16'h0000, "R3");
    set(0,0,0,2'b00,1,0,0,8'h00,0,0); step("R3"); step("R3");
    set(0,0,0,2'b01,0,0,0,8'h00,0,0); step("R3"); step("R3");
    chk(count_out, 16'h0000, "R3");
    step("R3");
    chk(count_out, 16'hFFFF, "R3");
    // R8: write beats preset, preset beats pulse
    set(0,0,1,2'b01,0,1,0,8'h12,0,0); step("R8");
    chk(count_out, 16'hFF12, "R8");
    set(0,1,0,2'b01,0,0,0,8'h00,0,0); step("R8");
    chk(count_out, 16'hFFFF, "R8");
    // R6: coherent two-byte read across a carry
    set(0,0,1,2'b00,1,1,1,8'h12,0,0); step("R4");
    set(0,0,1,2'b00,1,1,0,8'hFF,0,0); step("R4");
    set(1,0,0,2'b00,1,0,0,8'h00,1,1); step("R6");
    set(0,0,0,2'b00,1,0,0,8'h00,1,0); step("R6");
    chk({8'h00, rd_data}, 16'h00FF, "R6");
    chk(count_out, 16'h1300, "R6");

    // Random mix
    for (int k = 0; k < 4000; k++) begin
      set($urandom_range(0,2) == 0, $urandom_range(0,2) == 0, $urandom_range(0,3) == 0,
          2'($urandom_range(0,3)), $urandom_range(0,9) != 0, $urandom_range(0,5) == 0,
          1'($urandom_range(0,1)), 8'($urandom_range(0,255)),
          $urandom_range(0,2) == 0, 1'($urandom_range(0,1)));
      step("");
    end

    summary();
    $finish;
  end

endmodule